// File: doc/BRIEF.md
# Wavefront Matrix Multiply Array

This block computes the product C = A x B of two square N x N matrices of signed 16-bit values on an N x N grid of multiply-accumulate cells. A is written into one small memory per grid row on the left edge, and B into one small memory per grid column on the top edge. After a start pulse, the left memories stream their entries rightwards into the grid, one per step k, and the top memories stream theirs downwards. Each cell waits until it holds both an A operand from its left link and a B operand from its upper link. It then adds their product into a private 40-bit accumulator and passes A to the right and B downwards.

No global beat decides when a cell works. Every link is a one-slot elastic channel with a valid/taken handshake. A cell cannot send a new operand until its neighbour has taken the previous one, so consecutive recursions move across the grid as separate anti-diagonal fronts that never overlap. Cells in the last column drop the A operands they would pass on, and cells in the last row drop the B operands. Each feeder has a hold input that withholds operands, so the caller can inject any stall pattern without changing the result.

The flag `done` rises once the bottom-right cell has made its Nth accumulation. The product is then read one element at a time through a registered row/column read port.

Top module: `wavefront_mm`

## Requirements
- R1: Reset, and also a start pulse, clear every C accumulator to zero. A start pulse drives `done` low at the next clock edge.
- R2: After a run, reading row i, column j returns the sign-extended element (i,j) of A x B, which is the sum over k of A[i][k]*B[k][j].
- R3: `done` rises in the cycle after the bottom-right cell completes its Nth accumulation. It then stays high until the next start.
- R4: A cell consumes an A operand only in the same cycle that it consumes a B operand, and only while both of its output slots are empty. When B is withheld from column 1, the column 0 cells each accumulate exactly once and every other cell stays at zero.
- R5: An operand offered on any link stays offered, with unchanged data, until the receiving side takes it.
- R6: Any pattern of feeder holds that is eventually released gives the same result as a run with no holds.
- R7: The read port is registered. `rd_data` shows the element addressed in the previous cycle.
- R8: While `ld_en` is high, `ld_tgt` = 0 writes `ld_data` into A[ld_row][ld_col] and `ld_tgt` = 1 writes it into B[ld_row][ld_col].
- R9: While the row 0 left feeder is held, no cell accumulates and `done` stays low. Releasing the hold completes the run with the correct result.
- R10: While `done` is high, no operand remains on any link, and further cycles leave the results unchanged.
- R11: Full-scale operands such as (-32768)*(-32768) summed N times accumulate without wrap in 40 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Operand write strobe |
| ld_tgt | input | 1 | 0 selects matrix A, 1 selects matrix B |
| ld_row | input | IW | Row of the element being written |
| ld_col | input | IW | Column of the element being written |
| ld_data | input | DW | Signed operand value |
| start | input | 1 | Clears the accumulators and launches a run |
| hold_left | input | N | Per-row hold on the left feeders |
| hold_top | input | N | Per-column hold on the top feeders |
| done | output | 1 | Product complete |
| rd_row | input | IW | Read row select |
| rd_col | input | IW | Read column select |
| rd_data | output | AW | Registered signed result element |

## Verification
The hardest state to reach is a grid that is only partly filled. Here some cells hold an operand on one input with nothing on the other, and upstream cells are blocked by output slots that are still full. The bench reaches this state by withholding a single top feeder. It then checks the frozen accumulators, in which each column 0 cell has fired exactly once and every other cell is still zero, before releasing the hold. Table cases run with pseudo-random holds on the left feeders alone and on both edges, and the results are compared against a product the bench computes itself.

// File: rtl/wfm_pkg.sv
package wfm_pkg;
  typedef enum logic {
    TGT_A = 1'b0,
    TGT_B = 1'b1
  } ld_tgt_e;
endpackage

// File: rtl/wfm_feeder.sv
module wfm_feeder #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic          hold,
  output logic [DW-1:0] out_data,
  output logic          out_vld,
  input  logic          out_rdy
);
  localparam int KW = $clog2(N + 1);

  logic [DW-1:0] mem [N];
  logic [KW-1:0] k;
  logic          run;
  logic          can_load;

  // Operand store: one write port, one synchronous read port.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign can_load = run && (k < KW'(N)) && !hold && (!out_vld || out_rdy);

  always_ff @(posedge clk) begin
    if (rst) begin
      k        <= '0;
      run      <= 1'b0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else if (start) begin
      k       <= '0;
      run     <= 1'b1;
      out_vld <= 1'b0;
    end else if (can_load) begin
      out_data <= mem[k[IW-1:0]];
      out_vld  <= 1'b1;
      k        <= k + 1'b1;
    end else if (out_vld && out_rdy) begin
      out_vld <= 1'b0;
    end
  end
endmodule

// File: rtl/wfm_cell.sv
module wfm_cell #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int AW = 40,
  parameter int CW = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [DW-1:0]        a_in,
  input  logic                 a_vld,
  output logic                 a_rdy,
  input  logic [DW-1:0]        b_in,
  input  logic                 b_vld,
  output logic                 b_rdy,
  output logic [DW-1:0]        a_out,
  output logic                 a_ovld,
  input  logic                 a_ordy,
  output logic [DW-1:0]        b_out,
  output logic                 b_ovld,
  input  logic                 b_ordy,
  output logic signed [AW-1:0] acc,
  output logic                 fin
);
  logic                   fire;
  logic signed [2*DW-1:0] prod;
  logic [CW-1:0]          cnt;

  assign fire  = a_vld && b_vld && !a_ovld && !b_ovld;
  assign a_rdy = fire;
  assign b_rdy = fire;
  assign prod  = $signed(a_in) * $signed(b_in);
  assign fin   = (cnt == CW'(N));

  always_ff @(posedge clk) begin
    if (rst || start) begin
      acc    <= '0;
      cnt    <= '0;
      a_ovld <= 1'b0;
      b_ovld <= 1'b0;
      a_out  <= '0;
      b_out  <= '0;
    end else if (fire) begin
      acc    <= acc + AW'(prod);
      cnt    <= cnt + 1'b1;
      a_out  <= a_in;
      b_out  <= b_in;
      a_ovld <= 1'b1;
      b_ovld <= 1'b1;
    end else begin
      if (a_ovld && a_ordy) a_ovld <= 1'b0;
      if (b_ovld && b_ordy) b_ovld <= 1'b0;
    end
  end
endmodule

// File: rtl/wfm_readout.sv
module wfm_readout #(
  parameter int N  = 3,
  parameter int AW = 40,
  parameter int IW = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N*N-1:0][AW-1:0]    acc_all,
  input  logic [IW-1:0]             row,
  input  logic [IW-1:0]             col,
  output logic [AW-1:0]             data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data <= '0;
    end else begin
      data <= '0;
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N; c++) begin
          if (row == IW'(r) && col == IW'(c)) data <= acc_all[r*N+c];
        end
      end
    end
  end
endmodule

// File: rtl/wavefront_mm.sv
module wavefront_mm #(
  parameter int N  = 3,
  parameter int DW = 16,
  parameter int AW = 40,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_en,
  input  logic          ld_tgt,
  input  logic [IW-1:0] ld_row,
  input  logic [IW-1:0] ld_col,
  input  logic [DW-1:0] ld_data,
  input  logic          start,
  input  logic [N-1:0]  hold_left,
  input  logic [N-1:0]  hold_top,
  output logic          done,
  input  logic [IW-1:0] rd_row,
  input  logic [IW-1:0] rd_col,
  output logic [AW-1:0] rd_data
);
  import wfm_pkg::*;

  localparam int CW  = $clog2(N + 1);
  localparam int NLA = N * (N + 1);
  localparam int NLB = (N + 1) * N;

  // A links: index i*(N+1)+j feeds cell (i,j); j == N leaves the grid.
  logic [NLA-1:0]         av, ar;
  logic [NLA-1:0][DW-1:0] ad;
  // B links: index i*N+j feeds cell (i,j); i == N leaves the grid.
  logic [NLB-1:0]         bv, br;
  logic [NLB-1:0][DW-1:0] bd;

  logic [N*N-1:0][AW-1:0] acc_all;
  logic [N*N-1:0]         fin_all;

  for (genvar i = 0; i < N; i++) begin : g_left
    wfm_feeder #(.N(N), .DW(DW), .IW(IW)) feed_i (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .wr_en   (ld_en && (ld_tgt == TGT_A) && (ld_row == IW'(i))),
      .wr_idx  (ld_col),
      .wr_data (ld_data),
      .hold    (hold_left[i]),
      .out_data(ad[i*(N+1)]),
      .out_vld (av[i*(N+1)]),
      .out_rdy (ar[i*(N+1)])
    );
    assign ar[i*(N+1)+N] = 1'b1;
  end

  for (genvar j = 0; j < N; j++) begin : g_top
    wfm_feeder #(.N(N), .DW(DW), .IW(IW)) feed_i (
      .clk     (clk),
      .rst     (rst),
      .start   (start),
      .wr_en   (ld_en && (ld_tgt == TGT_B) && (ld_col == IW'(j))),
      .wr_idx  (ld_row),
      .wr_data (ld_data),
      .hold    (hold_top[j]),
      .out_data(bd[j]),
      .out_vld (bv[j]),
      .out_rdy (br[j])
    );
    assign br[N*N+j] = 1'b1;
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_col
      logic signed [AW-1:0] acc_c;
      wfm_cell #(.N(N), .DW(DW), .AW(AW), .CW(CW)) cell_i (
        .clk   (clk),
        .rst   (rst),
        .start (start),
        .a_in  (ad[i*(N+1)+j]),
        .a_vld (av[i*(N+1)+j]),
        .a_rdy (ar[i*(N+1)+j]),
        .b_in  (bd[i*N+j]),
        .b_vld (bv[i*N+j]),
        .b_rdy (br[i*N+j]),
        .a_out (ad[i*(N+1)+j+1]),
        .a_ovld(av[i*(N+1)+j+1]),
        .a_ordy(ar[i*(N+1)+j+1]),
        .b_out (bd[(i+1)*N+j]),
        .b_ovld(bv[(i+1)*N+j]),
        .b_ordy(br[(i+1)*N+j]),
        .acc   (acc_c),
        .fin   (fin_all[i*N+j])
      );
      assign acc_all[i*N+j] = acc_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || start) done <= 1'b0;
    else if (fin_all[N*N-1]) done <= 1'b1;
  end

  wfm_readout #(.N(N), .AW(AW), .IW(IW)) rdo_i (
    .clk    (clk),
    .rst    (rst),
    .acc_all(acc_all),
    .row    (rd_row),
    .col    (rd_col),
    .data   (rd_data)
  );
endmodule

// File: rtl/wfm_checker.sv
module wfm_checker #(
  parameter int N  = 3,
  parameter int DW = 16
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           start,
  input logic                           done,
  input logic [N*(N+1)-1:0]             av,
  input logic [N*(N+1)-1:0]             ar,
  input logic [N*(N+1)-1:0][DW-1:0]     ad,
  input logic [(N+1)*N-1:0]             bv,
  input logic [(N+1)*N-1:0]             br,
  input logic [(N+1)*N-1:0][DW-1:0]     bd
);
  localparam int NLA = N * (N + 1);
  localparam int NLB = (N + 1) * N;

  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (rst) start |=> !done); // R1
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) (done && !start) |=> done); // R3
  AST_DONE_DRAINED: assert property (@(posedge clk) disable iff (rst) done |-> (av == '0 && bv == '0)); // R10

  for (genvar l = 0; l < NLA; l++) begin : g_al
    AST_A_LINK_HOLD: assert property (@(posedge clk) disable iff (rst) (av[l] && !ar[l] && !start) |=> (av[l] && $stable(ad[l]))); // R5
  end
  for (genvar l = 0; l < NLB; l++) begin : g_bl
    AST_B_LINK_HOLD: assert property (@(posedge clk) disable iff (rst) (bv[l] && !br[l] && !start) |=> (bv[l] && $stable(bd[l]))); // R5
  end
  for (genvar i = 0; i < N; i++) begin : g_pi
    for (genvar j = 0; j < N; j++) begin : g_pj
      AST_PAIRED_TAKE: assert property (@(posedge clk) disable iff (rst) ar[i*(N+1)+j] |-> (av[i*(N+1)+j] && bv[i*N+j] && br[i*N+j])); // R4
    end
  end
endmodule

bind wavefront_mm wfm_checker #(.N(N), .DW(DW)) chk_i (
  .clk  (clk),
  .rst  (rst),
  .start(start),
  .done (done),
  .av   (av),
  .ar   (ar),
  .ad   (ad),
  .bv   (bv),
  .br   (br),
  .bd   (bd)
);

// File: tb/wavefront_mm_tb_top.sv
`timescale 1ns/1ps
module wavefront_mm_tb_top;
  localparam int NN = 3;
  localparam int NC = 4;

  localparam int TA [NC][9] = '{
    '{1, 0, 0, 0, 1, 0, 0, 0, 1},
    '{1, 2, 3, 4, 5, 6, 7, 8, 9},
    '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768},
    '{32767, -32768, 100, -1, 0, 32767, 5, -7, 11}
  };
  localparam int TB [NC][9] = '{
    '{1, 2, 3, 4, 5, 6, 7, 8, 9},
    '{-9, 8, -7, 6, -5, 4, -3, 2, -1},
    '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768},
    '{-32768, 32767, -2, 3, 32767, -32768, -100, 1, 0}
  };
  localparam int MODE [NC] = '{0, 1, 2, 1};

  logic          clk = 1'b0;
  logic          rst;
  logic          ld_en, ld_tgt, start, done;
  logic [1:0]    ld_row, ld_col, rd_row, rd_col;
  logic [15:0]   ld_data;
  logic [NN-1:0] hold_left, hold_top;
  logic [39:0]   rd_data;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  wavefront_mm #(.N(NN), .DW(16), .AW(40)) dut_i (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_tgt(ld_tgt),
    .ld_row(ld_row), .ld_col(ld_col), .ld_data(ld_data),
    .start(start), .hold_left(hold_left), .hold_top(hold_top),
    .done(done), .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data)
  );

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint ref_c(int cs, int r, int c);
    longint s = 0;
    for (int k = 0; k < NN; k++) s += longint'(TA[cs][r*NN+k]) * longint'(TB[cs][k*NN+c]);
    return s;
  endfunction

  task automatic read_c(int r, int c, output longint v);
    @(negedge clk);
    rd_row = 2'(r);
    rd_col = 2'(c);
    @(negedge clk);
    v = longint'($signed(rd_data));
  endtask

  task automatic load_case(int cs);
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < NN; r++) begin
        for (int c = 0; c < NN; c++) begin
          @(negedge clk);
          ld_en   = 1'b1;
          ld_tgt  = m[0];
          ld_row  = 2'(r);
          ld_col  = 2'(c);
          ld_data = 16'((m == 0) ? TA[cs][r*NN+c] : TB[cs][r*NN+c]);
        end
      end
    end
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R1 done low after start", longint'(done), 0);
  endtask

  task automatic wait_done(int mode);
    int cyc = 0;
    while (!done && cyc < 4000) begin
      for (int i = 0; i < NN; i++) begin
        hold_left[i] = (mode >= 1) && (((cyc * 5 + i * 3) % 7) < 3);
        hold_top[i]  = (mode == 2) && (((cyc * 3 + i * 5) % 5) < 2);
      end
      @(negedge clk);
      cyc++;
    end
    hold_left = '0;
    hold_top  = '0;
    chk("R3 done within bound", longint'(done), 1);
  endtask

  task automatic check_all(int cs, string tag);
    longint v;
    for (int r = 0; r < NN; r++) begin
      for (int c = 0; c < NN; c++) begin
        read_c(r, c, v);
        chk(tag, v, ref_c(cs, r, c));
      end
    end
  endtask

  task automatic check_zero(string tag);
    longint v;
    for (int r = 0; r < NN; r++) begin
      for (int c = 0; c < NN; c++) begin
        read_c(r, c, v);
        chk(tag, v, 0);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    longint v;
    rst = 1'b1; ld_en = 1'b0; ld_tgt = 1'b0; ld_row = '0; ld_col = '0; ld_data = '0;
    start = 1'b0; hold_left = '0; hold_top = '0; rd_row = '0; rd_col = '0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R3 done low after reset", longint'(done), 0);
    check_zero("R1 reset clears C");

    // Table walk: R2 R6 R8 R11 (R5 with stalls)
    for (int cs = 0; cs < NC; cs++) begin
      load_case(cs);
      pulse_start();
      wait_done(MODE[cs]);
      check_all(cs, (MODE[cs] == 0) ? "R2 R8 R11 product" : "R5 R6 stalled product");
    end

    // R3 sticky, R10 nothing changes after done
    repeat (30) @(negedge clk);
    chk("R3 done sticky", longint'(done), 1);
    check_all(NC - 1, "R10 results stable after done");

    // R7 back-to-back addresses
    @(negedge clk); rd_row = 2'd2; rd_col = 2'd1;
    @(negedge clk); chk("R7 read latency 2,1", longint'($signed(rd_data)), ref_c(NC - 1, 2, 1));
    rd_row = 2'd0; rd_col = 2'd2;
    @(negedge clk); chk("R7 read latency 0,2", longint'($signed(rd_data)), ref_c(NC - 1, 0, 2));

    // R1 start clears while everything is held
    @(negedge clk); hold_left = '1; hold_top = '1;
    pulse_start();
    check_zero("R1 start clears C");
    hold_left = '0; hold_top = '0;
    wait_done(0);
    check_all(NC - 1, "R1 rerun after clear");

    // R9 row 0 left feeder held
    load_case(1);
    @(negedge clk); hold_left = 3'b001;
    pulse_start();
    repeat (60) @(negedge clk);
    chk("R9 done low while held", longint'(done), 0);
    check_zero("R9 no accumulation while held");
    hold_left = '0;
    wait_done(0);
    check_all(1, "R9 result after release");

    // R4 column 1 top feeder held: partial fill
    @(negedge clk); hold_top = 3'b010;
    pulse_start();
    repeat (60) @(negedge clk);
    for (int r = 0; r < NN; r++) begin
      for (int c = 0; c < NN; c++) begin
        read_c(r, c, v);
        chk("R4 partial fill", v, (c == 0) ? longint'(TA[1][r*NN]) * longint'(TB[1][0]) : 0);
      end
    end
    hold_top = '0;
    wait_done(0);
    check_all(1, "R4 result after release");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule